// File: doc/BRIEF.md
# Dual-Channel Disk Card Bus Decode and Interrupt Glue

This block sits between a byte-wide host bus and two disk channels on an expansion card. It turns host reads and writes into per-channel task-file chip selects with a 3-bit register index, plus a chip select for each channel's control/alternate-status register. Each channel has an interrupt-enable latch. A write of any value to the latch's address sets it, and a read of that address clears it. A separate status address returns the channel's raw interrupt request. The host sees one registered interrupt line that combines both channels.

A small configuration register sits at offset 0 and is reachable at all times. One bit opens the fast access window. While the window is closed, the channel registers are hidden and the card answers with its 4-bit identity code instead. Another bit of the same register gives the card's one DMA request/acknowledge pair to channel 0 or channel 1. The drives appear only as interrupt and DMA request inputs, and the DMA engine appears only as request and acknowledge pins.

Top module: `ide_card_glue`

## Requirements
- R1: After reset both interrupt-enable latches are clear, `irq_o` is 0 and the configuration register reads 0x00.
- R2: While the window is closed, a read at 0x2280 + 4·n (n = 0..3) returns bit n of the identity code 3 in bit 0, and zero in bits 7:1. The expected values are 1, 1, 0, 0.
- R3: Offset 0x0000 is the configuration register and is accessible at all times. Bit 5 opens the fast window and bit 0 is the DMA channel select. A read returns only these two bits, with all other bits 0.
- R4: With the window open, an access at base + 64·i (base 0x2000 for channel 0, 0x3000 for channel 1, i = 0..7) asserts `tf_cs_o[ch]` with `tf_idx_o` = i. The access also asserts `tf_rd_o` or `tf_wr_o`. A read returns `tf_rdata_i`.
- R5: With the window open, an access at 0x2380 or 0x3380 asserts `ctl_cs_o[ch]` with the same read/write strobes and read data path as R4.
- R6: With the window open, a write of any data value to 0x2200 or 0x3200 sets that channel's interrupt enable.
- R7: With the window open, a read of 0x2200 or 0x3200 returns 0 and clears only that channel's interrupt enable.
- R8: With the window open, a read of 0x2290 or 0x3290 returns that channel's raw request in bit 0 and leaves both enables unchanged.
- R9: `irq_o` is the OR over channels of (enable AND raw request), delayed by one clock register.
- R10: While the window is closed, all channel addresses read 0, assert no chip select and leave the enables unchanged. While the window is open, the identity addresses read 0.
- R11: `dma_req_o` follows only the selected channel's request, and `dma_ack_i` reaches only the selected channel's `dma_ack_o` bit. The unselected channel's request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hreq_i | input | 1 | Host access valid for this cycle |
| hwe_i | input | 1 | 1 = write, 0 = read |
| haddr_i | input | 14 | Host byte address |
| hwdata_i | input | 8 | Host write data |
| hrdata_o | output | 8 | Host read data (combinational) |
| tf_cs_o | output | 2 | Task-file chip select per channel |
| ctl_cs_o | output | 2 | Control register chip select per channel |
| tf_idx_o | output | 3 | Task-file register index |
| tf_rd_o | output | 1 | Drive-side read strobe |
| tf_wr_o | output | 1 | Drive-side write strobe |
| tf_wdata_o | output | 8 | Drive-side write data |
| tf_rdata_i | input | 8 | Drive-side read data |
| drv_irq_i | input | 2 | Raw interrupt request per channel |
| irq_o | output | 1 | Combined host interrupt (registered) |
| dma_req_i | input | 2 | DMA request per channel |
| dma_req_o | output | 1 | DMA request to controller |
| dma_ack_i | input | 1 | DMA acknowledge from controller |
| dma_ack_o | output | 2 | DMA acknowledge per channel |

## Verification
Suppose an enable latch is set or cleared wrongly, or a read clears the wrong channel. The fault shows on `irq_o` at the second clock edge after the access, once the raw request is held high. A stale window bit shows at once as a wrong read value or a chip select on the same cycle. A wrong DMA select shows at once on `dma_req_o` and `dma_ack_o`. The bench holds the raw requests high across the enable sequence so that each latch state can be seen on `irq_o`.

// File: rtl/ide_glue_pkg.sv
package ide_glue_pkg;
  localparam int AW  = 14;
  localparam int DW  = 8;
  localparam int NCH = 2;
  localparam int SW  = $clog2(NCH);
  localparam int IW  = 3;

  localparam logic [AW-1:0] CFG_ADDR   = 14'h0000;
  localparam logic [AW-1:0] IDENT_BASE = 14'h2280;
  localparam logic [11:0]   OFF_IEN    = 12'h200;
  localparam logic [11:0]   OFF_STAT   = 12'h290;
  localparam logic [11:0]   OFF_CTL    = 12'h380;
  localparam int            CFG_FAST_BIT = 5;
  localparam int            CFG_SEL_BIT  = 0;
  localparam logic [3:0]    CARD_ID      = 4'd3;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_CFG, ACC_IDENT, ACC_TF, ACC_CTL, ACC_IEN, ACC_STAT
  } acc_e;

  typedef struct packed {
    acc_e          kind;
    logic [SW-1:0] ch;
    logic [IW-1:0] idx;
    logic [1:0]    id_bit;
  } dec_t;
endpackage

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
  import ide_glue_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          fast_i,
  output dec_t          dec_o
);
  logic [11:0] off;
  assign off = addr_i[11:0];

  always_comb begin
    dec_o        = '0;
    dec_o.kind   = ACC_NONE;
    if (req_i) begin
      if (addr_i == CFG_ADDR) begin
        dec_o.kind = ACC_CFG;
      end else if (!fast_i) begin
        if (addr_i[AW-1:4] == IDENT_BASE[AW-1:4] && addr_i[1:0] == 2'b00) begin
          dec_o.kind   = ACC_IDENT;
          dec_o.id_bit = addr_i[3:2];
        end
      end else if (addr_i[AW-1]) begin
        dec_o.ch = addr_i[12];
        if (off[11:9] == 3'b000 && off[5:0] == 6'd0) begin
          dec_o.kind = ACC_TF;
          dec_o.idx  = off[8:6];
        end else if (off == OFF_IEN) begin
          dec_o.kind = ACC_IEN;
        end else if (off == OFF_STAT) begin
          dec_o.kind = ACC_STAT;
        end else if (off == OFF_CTL) begin
          dec_o.kind = ACC_CTL;
        end
      end
    end
  end

  // R10: identity space and channel space never decode together
  a_r10_ident_closed_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o.kind == ACC_IDENT) |-> !fast_i);
  a_r10_chan_open_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o.kind inside {ACC_TF, ACC_CTL, ACC_IEN, ACC_STAT}) |-> fast_i);
endmodule

// File: rtl/glue_irq_ctrl.sv
module glue_irq_ctrl
  import ide_glue_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] drv_irq_i,
  output logic [NCH-1:0] en_o,
  output logic           irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       en_o[c] <= 1'b0;
      else if (set_i[c]) en_o[c] <= 1'b1;
      else if (clr_i[c]) en_o[c] <= 1'b0;
    end

    a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[c] |=> en_o[c]);
    a_r7_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[c] && !set_i[c]) |=> !en_o[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(en_o & drv_irq_i);
  end

  // R8: enables move only on a set or clear strobe
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(en_o));
  // R9: interrupt rises only when some enable was held
  a_r9_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_o != '0));
endmodule

// File: rtl/glue_dma_steer.sv
module glue_dma_steer
  import ide_glue_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [SW-1:0]  sel_i,
  input  logic [NCH-1:0] dma_req_i,
  input  logic           dma_ack_i,
  output logic           dma_req_o,
  output logic [NCH-1:0] dma_ack_o
);
  assign dma_req_o = dma_req_i[sel_i];

  for (genvar c = 0; c < NCH; c++) begin : g_ack
    assign dma_ack_o[c] = dma_ack_i && (sel_i == SW'(c));
  end

  // R11: at most one channel is acknowledged
  a_r11_one_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dma_ack_o));
  a_r11_ack_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_ack_o != '0) |-> dma_ack_i);
endmodule

// File: rtl/ide_card_glue.sv
module ide_card_glue
  import ide_glue_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hreq_i,
  input  logic           hwe_i,
  input  logic [AW-1:0]  haddr_i,
  input  logic [DW-1:0]  hwdata_i,
  output logic [DW-1:0]  hrdata_o,
  output logic [NCH-1:0] tf_cs_o,
  output logic [NCH-1:0] ctl_cs_o,
  output logic [IW-1:0]  tf_idx_o,
  output logic           tf_rd_o,
  output logic           tf_wr_o,
  output logic [DW-1:0]  tf_wdata_o,
  input  logic [DW-1:0]  tf_rdata_i,
  input  logic [NCH-1:0] drv_irq_i,
  output logic           irq_o,
  input  logic [NCH-1:0] dma_req_i,
  output logic           dma_req_o,
  input  logic           dma_ack_i,
  output logic [NCH-1:0] dma_ack_o
);
  logic          cfg_fast_q;
  logic [SW-1:0] cfg_sel_q;
  dec_t          dec;
  logic [NCH-1:0] ien_set, ien_clr, ien;
  logic          drv_acc;

  glue_addr_decode i_dec (
    .clk_i, .rst_ni,
    .req_i (hreq_i),
    .addr_i(haddr_i),
    .fast_i(cfg_fast_q),
    .dec_o (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_fast_q <= 1'b0;
      cfg_sel_q  <= '0;
    end else if (dec.kind == ACC_CFG && hwe_i) begin
      cfg_fast_q <= hwdata_i[CFG_FAST_BIT];
      cfg_sel_q  <= hwdata_i[CFG_SEL_BIT +: SW];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit         = (dec.ch == SW'(c));
    assign tf_cs_o[c]  = (dec.kind == ACC_TF)  && hit;
    assign ctl_cs_o[c] = (dec.kind == ACC_CTL) && hit;
    assign ien_set[c]  = (dec.kind == ACC_IEN) && hit && hwe_i;
    assign ien_clr[c]  = (dec.kind == ACC_IEN) && hit && !hwe_i;
  end

  assign drv_acc    = (dec.kind == ACC_TF) || (dec.kind == ACC_CTL);
  assign tf_idx_o   = dec.idx;
  assign tf_rd_o    = drv_acc && !hwe_i;
  assign tf_wr_o    = drv_acc && hwe_i;
  assign tf_wdata_o = hwdata_i;

  always_comb begin
    hrdata_o = '0;
    if (!hwe_i) begin
      unique case (dec.kind)
        ACC_CFG: begin
          hrdata_o[CFG_FAST_BIT]       = cfg_fast_q;
          hrdata_o[CFG_SEL_BIT +: SW]  = cfg_sel_q;
        end
        ACC_IDENT:       hrdata_o[0] = CARD_ID[dec.id_bit];
        ACC_STAT:        hrdata_o[0] = drv_irq_i[dec.ch];
        ACC_TF, ACC_CTL: hrdata_o    = tf_rdata_i;
        default:         hrdata_o    = '0;
      endcase
    end
  end

  glue_irq_ctrl i_irq (
    .clk_i, .rst_ni,
    .set_i    (ien_set),
    .clr_i    (ien_clr),
    .drv_irq_i(drv_irq_i),
    .en_o     (ien),
    .irq_o    (irq_o)
  );

  glue_dma_steer i_dma (
    .clk_i, .rst_ni,
    .sel_i    (cfg_sel_q),
    .dma_req_i(dma_req_i),
    .dma_ack_i(dma_ack_i),
    .dma_req_o(dma_req_o),
    .dma_ack_o(dma_ack_o)
  );

  // R10: closed window drives no drive-side select
  a_r10_no_cs_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_fast_q |-> (tf_cs_o == '0 && ctl_cs_o == '0 && !tf_rd_o && !tf_wr_o));
  // R3: config write lands in the window bit
  a_r3_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hreq_i && hwe_i && haddr_i == CFG_ADDR) |=> cfg_fast_q == $past(hwdata_i[CFG_FAST_BIT]));
  // R4: at most one drive-side select at a time
  a_r4_one_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tf_cs_o, ctl_cs_o}));
endmodule

// File: tb/test_ide_card_glue.sv
module test_ide_card_glue;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hreq = 1'b0, hwe = 1'b0;
  logic [13:0] haddr = '0;
  logic [7:0]  hwdata = '0, hrdata;
  logic [1:0]  tf_cs, ctl_cs;
  logic [2:0]  tf_idx;
  logic        tf_rd, tf_wr, irq;
  logic [7:0]  tf_wdata;
  logic [7:0]  tf_rdata = 8'hA5;
  logic [1:0]  drv_irq = '0, dma_req = '0, dma_ack;
  logic        dma_req_o, dma_ack_i = 1'b0;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  ide_card_glue i_ide_card_glue (
    .clk_i(clk), .rst_ni(rst_ni),
    .hreq_i(hreq), .hwe_i(hwe), .haddr_i(haddr), .hwdata_i(hwdata), .hrdata_o(hrdata),
    .tf_cs_o(tf_cs), .ctl_cs_o(ctl_cs), .tf_idx_o(tf_idx), .tf_rd_o(tf_rd), .tf_wr_o(tf_wr),
    .tf_wdata_o(tf_wdata), .tf_rdata_i(tf_rdata), .drv_irq_i(drv_irq), .irq_o(irq),
    .dma_req_i(dma_req), .dma_req_o(dma_req_o), .dma_ack_i(dma_ack_i), .dma_ack_o(dma_ack)
  );

  // snapshot of combinational outputs during an access
  logic [7:0] s_rd;
  logic [1:0] s_tf, s_ctl;
  logic [2:0] s_idx;
  logic       s_rds, s_wrs;
  logic [7:0] s_wd;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic access(input logic we, input logic [13:0] a, input logic [7:0] d);
    hreq = 1'b1; hwe = we; haddr = a; hwdata = d;
    #1;
    s_rd = hrdata; s_tf = tf_cs; s_ctl = ctl_cs; s_idx = tf_idx;
    s_rds = tf_rd; s_wrs = tf_wr; s_wd = tf_wdata;
    @(negedge clk);
    hreq = 1'b0; hwe = 1'b0; haddr = '0; hwdata = '0;
  endtask

  // {we, chk, drv_irq[1:0], addr[15:0], wdata[7:0], exp[7:0]}
  localparam int NV = 18;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0,1'b1,2'b01,16'h0000,8'h00,8'h00}, // R1 R3 reset config
    {1'b0,1'b1,2'b00,16'h2280,8'h00,8'h01}, // R2 id bit0
    {1'b0,1'b1,2'b00,16'h2284,8'h00,8'h01}, // R2 id bit1
    {1'b0,1'b1,2'b00,16'h2288,8'h00,8'h00}, // R2 id bit2
    {1'b0,1'b1,2'b00,16'h228C,8'h00,8'h00}, // R2 id bit3
    {1'b0,1'b1,2'b11,16'h2290,8'h00,8'h00}, // R10 status hidden
    {1'b0,1'b1,2'b00,16'h2040,8'h00,8'h00}, // R10 taskfile hidden
    {1'b1,1'b0,2'b00,16'h0000,8'hFF,8'h00}, // open, select ch1
    {1'b0,1'b1,2'b00,16'h0000,8'h00,8'h21}, // R3 only two bits kept
    {1'b0,1'b1,2'b00,16'h2280,8'h00,8'h00}, // R10 id hidden when open
    {1'b0,1'b1,2'b01,16'h2290,8'h00,8'h01}, // R8 ch0 status
    {1'b0,1'b1,2'b01,16'h3290,8'h00,8'h00}, // R8 ch1 status low
    {1'b0,1'b1,2'b10,16'h3290,8'h00,8'h01}, // R8 ch1 status high
    {1'b0,1'b1,2'b00,16'h2040,8'h00,8'hA5}, // R4 taskfile read
    {1'b0,1'b1,2'b00,16'h3380,8'h00,8'hA5}, // R5 control read
    {1'b0,1'b1,2'b00,16'h2200,8'h00,8'h00}, // R7 enable read is 0
    {1'b1,1'b0,2'b00,16'h0000,8'h00,8'h00}, // close
    {1'b0,1'b1,2'b00,16'h0000,8'h00,8'h00}  // R3 closed readback
  };

  initial begin
    #(5.0 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    check("R1 irq_o in reset", 16'(irq), 16'h0);
    rst_ni = 1'b1;
    tick();
    check("R1 irq_o after reset", 16'(irq), 16'h0);
    check("R11 no ack after reset", 16'(dma_ack), 16'h0);

    for (int i = 0; i < NV; i++) begin
      drv_irq = VEC[i][33:32];
      access(VEC[i][35], VEC[i][29:16], VEC[i][15:8]);
      if (VEC[i][34])
        check($sformatf("vec %0d (R1/R2/R3/R4/R5/R7/R8/R10) read data", i), 16'(s_rd), 16'(VEC[i][7:0]));
    end
    drv_irq = '0;

    // R11 DMA steering, channel 0 selected
    access(1'b1, 14'h0000, 8'h20);
    dma_req = 2'b10; #1;
    check("R11 sel0 ignores ch1 req", 16'(dma_req_o), 16'h0);
    dma_req = 2'b01; dma_ack_i = 1'b1; #1;
    check("R11 sel0 passes ch0 req", 16'(dma_req_o), 16'h1);
    check("R11 sel0 ack to ch0", 16'(dma_ack), 16'h1);
    tick();
    access(1'b1, 14'h0000, 8'h21);
    dma_req = 2'b01; #1;
    check("R11 sel1 ignores ch0 req", 16'(dma_req_o), 16'h0);
    dma_req = 2'b10; #1;
    check("R11 sel1 passes ch1 req", 16'(dma_req_o), 16'h1);
    check("R11 sel1 ack to ch1", 16'(dma_ack), 16'h2);
    dma_ack_i = 1'b0; dma_req = '0;
    tick();

    // R4 / R5 drive-side strobes
    access(1'b0, 14'h31C0, 8'h00);
    check("R4 ch1 cs", 16'(s_tf), 16'h2);
    check("R4 idx 7", 16'(s_idx), 16'h7);
    check("R4 read strobe", 16'({s_rds, s_wrs}), 16'h2);
    access(1'b1, 14'h2380, 8'h5A);
    check("R5 ch0 ctl cs", 16'({s_ctl, s_tf}), 16'h4);
    check("R5 write strobe and data", 16'({s_rds, s_wrs, s_wd}), 16'h15A);

    // R6/R7/R8/R9 enable latches
    drv_irq = 2'b11;
    access(1'b1, 14'h2200, 8'h00);        // R6 any value sets
    check("R9 irq_o one cycle late", 16'(irq), 16'h0);
    tick();
    check("R6 ch0 enable set", 16'(irq), 16'h1);
    access(1'b0, 14'h3200, 8'h00); tick();
    check("R7 ch1 read keeps ch0", 16'(irq), 16'h1);
    access(1'b0, 14'h2290, 8'h00); tick();
    check("R8 status read keeps enable", 16'(irq), 16'h1);
    access(1'b0, 14'h2200, 8'h00); tick();
    check("R7 ch0 read clears", 16'(irq), 16'h0);
    access(1'b1, 14'h3200, 8'hC3); tick();
    check("R6 ch1 enable set", 16'(irq), 16'h1);
    drv_irq = 2'b01; tick();
    check("R9 masked by ch0 enable", 16'(irq), 16'h0);
    access(1'b0, 14'h3200, 8'h00);

    // R10 closed window ignores enable write
    access(1'b1, 14'h0000, 8'h00);
    access(1'b1, 14'h2200, 8'hFF);
    check("R10 closed no cs", 16'({s_tf, s_ctl}), 16'h0);
    drv_irq = 2'b11;
    access(1'b1, 14'h0000, 8'h20);
    tick(); tick();
    check("R10 closed write had no effect", 16'(irq), 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule